// File: doc/BRIEF.md
# Bus Arbitration and Selection Controller

This block lets one device win ownership of a shared 8-line parallel bus and then address a second device. All bus signals are active-low. Each device releases a line by driving 1 and asserts it by driving 0, so the level on the bus is the AND of every driver. A request names the device's own ID and the ID of the target. The controller waits until the busy and select lines have both been high long enough. It then asserts busy and pulls low the data line whose index equals its own ID. After a settling window it reads the data lines back. If any line above its own index is low, it has lost. It withdraws and tries again as soon as the bus is free once more.

The winner pulls select low and marks both its own line and the target's line. After one clock it lets go of busy and waits for the target to pull busy low. A target reply within the timeout completes the selection. If the timeout runs out first, the controller reports a failure. While data lines are driven, the controller also drives a parity line that keeps the number of asserted lines odd. The controller only drives outputs, and the bench combines them with other devices to form the bus levels that come back on the inputs.

Top module: `idbus_selector`

## Requirements
- R1: After reset every bus output is released (1) and `busy`, `arb_lost`, `sel_ok` and `sel_fail` are 0.
- R2: A `start` whose `own_id` equals `tgt_id` is ignored. A `start` that arrives while `busy` is 1 is ignored and does not change the lines being driven.
- R3: Arbitration begins only after the controller has seen busy and select both high on FREE_CLKS consecutive clock edges. Any edge on which either line is low restarts the count, and this wait also applies after a lost arbitration.
- R4: During arbitration the controller holds its busy output low and its select output released. It asserts exactly one data line, the one with index `own_id`.
- R5: If, ARB_CLKS edges into arbitration, any data line with an index above `own_id` reads low, the controller releases every line. It pulses `arb_lost` for one cycle, stays busy and returns to waiting for a free bus.
- R6: A winner drives select low together with data lines `own_id` and `tgt_id`, with busy still low, for one clock. It then releases busy while keeping select and both data lines asserted.
- R7: Whenever any data line is driven, the parity output makes the total number of asserted lines among the eight data lines and the parity line odd. When no data line is driven, the parity output is released.
- R8: Busy read low while the controller waits for the target makes it pulse `sel_ok` and release every line in the same cycle.
- R9: If the target has not answered after SEL_TMO clock edges of waiting, the controller pulses `sel_fail` and releases every line.
- R10: Lines asserted below `own_id` during arbitration do not cause a loss, so the highest contending ID wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to arbitrate and select |
| own_id | input | ID_W | This device's ID, captured on start |
| tgt_id | input | ID_W | Target ID, captured on start |
| bsy_in_n | input | 1 | Busy level seen on the bus |
| sel_in_n | input | 1 | Select level seen on the bus |
| db_in_n | input | 2**ID_W | Data line levels seen on the bus |
| bsy_out_n | output | 1 | Busy drive (0 asserts) |
| sel_out_n | output | 1 | Select drive (0 asserts) |
| db_out_n | output | 2**ID_W | Data line drive (0 asserts) |
| dbp_out_n | output | 1 | Parity line drive (0 asserts) |
| busy | output | 1 | A request is in progress |
| arb_lost | output | 1 | One-cycle pulse: arbitration lost |
| sel_ok | output | 1 | One-cycle pulse: target answered |
| sel_fail | output | 1 | One-cycle pulse: selection timed out |

## Verification
Contention is tried in three patterns. Competitors that assert higher and lower lines together show that only higher lines cause a loss and a retry. Competitors that assert only lower lines show that the controller wins. A clean bus shows the basic sequence and the exact bus-free delay. A target that answers after a few cycles is set against a target that never answers, which separates success from a timeout measured to the exact edge. A self-addressed request and a request issued in the middle of a selection show that both are ignored.

// File: rtl/idbus_selector.sv
module idbus_selector #(
  parameter int ID_W      = 3,
  parameter int FREE_CLKS = 4,
  parameter int ARB_CLKS  = 3,
  parameter int SEL_TMO   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ID_W-1:0]      own_id,
  input  logic [ID_W-1:0]      tgt_id,
  input  logic                 bsy_in_n,
  input  logic                 sel_in_n,
  input  logic [(1<<ID_W)-1:0] db_in_n,
  output logic                 bsy_out_n,
  output logic                 sel_out_n,
  output logic [(1<<ID_W)-1:0] db_out_n,
  output logic                 dbp_out_n,
  output logic                 busy,
  output logic                 arb_lost,
  output logic                 sel_ok,
  output logic                 sel_fail
);
  localparam int DB_W  = 1 << ID_W;
  localparam int MAXAF = (FREE_CLKS > ARB_CLKS) ? FREE_CLKS : ARB_CLKS;
  localparam int MAXC  = (MAXAF > SEL_TMO) ? MAXAF : SEL_TMO;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_FREE, S_ARB, S_SEL, S_WAIT} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic [ID_W-1:0] own_q, tgt_q;
  logic [DB_W-1:0] own_bit, tgt_bit, drive, hi_mask;
  logic            bus_free, higher, par;

  assign bus_free = bsy_in_n & sel_in_n;
  assign own_bit  = DB_W'(1) << own_q;
  assign tgt_bit  = DB_W'(1) << tgt_q;
  assign hi_mask  = ({DB_W{1'b1}} << own_q) << 1;
  assign higher   = |(~db_in_n & hi_mask);

  always_comb begin
    drive = '0;
    if (st == S_ARB) drive = own_bit;
    else if (st == S_SEL || st == S_WAIT) drive = own_bit | tgt_bit;
  end

  assign par       = (|drive) & ~(^drive);
  assign db_out_n  = ~drive;
  assign dbp_out_n = ~par;
  assign bsy_out_n = ~(st == S_ARB || st == S_SEL);
  assign sel_out_n = ~(st == S_SEL || st == S_WAIT);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      own_q    <= '0;
      tgt_q    <= '0;
      arb_lost <= 1'b0;
      sel_ok   <= 1'b0;
      sel_fail <= 1'b0;
    end else begin
      arb_lost <= 1'b0;
      sel_ok   <= 1'b0;
      sel_fail <= 1'b0;
      unique case (st)
        S_IDLE:
          if (start && own_id != tgt_id) begin
            own_q <= own_id;
            tgt_q <= tgt_id;
            cnt   <= '0;
            st    <= S_FREE;
          end
        S_FREE:
          if (!bus_free) cnt <= '0;
          else if (cnt == CNT_W'(FREE_CLKS - 1)) begin
            cnt <= '0;
            st  <= S_ARB;
          end else cnt <= cnt + 1'b1;
        S_ARB:
          if (cnt == CNT_W'(ARB_CLKS - 1)) begin
            cnt <= '0;
            if (higher) begin
              arb_lost <= 1'b1;
              st       <= S_FREE;
            end else st <= S_SEL;
          end else cnt <= cnt + 1'b1;
        S_SEL: begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT:
          if (!bsy_in_n) begin
            sel_ok <= 1'b1;
            st     <= S_IDLE;
          end else if (cnt == CNT_W'(SEL_TMO - 1)) begin
            sel_fail <= 1'b1;
            st       <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idbus_selector_chk.sv
module idbus_selector_chk #(
  parameter int ID_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bsy_in_n,
  input logic                 sel_in_n,
  input logic [(1<<ID_W)-1:0] db_in_n,
  input logic                 bsy_out_n,
  input logic                 sel_out_n,
  input logic [(1<<ID_W)-1:0] db_out_n,
  input logic                 dbp_out_n,
  input logic                 arb_lost,
  input logic                 sel_ok,
  input logic                 sel_fail,
  input logic [ID_W-1:0]      own_q
);
  // R3
  arb_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_out_n) |-> ($past(bsy_in_n) && $past(sel_in_n)));
  // R6
  sel_after_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_out_n) |-> !$past(bsy_out_n));
  // R7
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~db_out_n != '0) |-> ($countones(~{db_out_n, dbp_out_n}) % 2 == 1));
  // R4
  few_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~db_out_n) <= 2);
  // R5
  loss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (($past(~db_in_n) >> $past(own_q)) > 1));
  // R8
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> !$past(bsy_in_n));
  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_lost, sel_ok, sel_fail}));
endmodule

bind idbus_selector idbus_selector_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/tb_idbus_selector.sv
module tb_idbus_selector;
  localparam int ID_W = 3, FREE = 4, ARB = 3, TMO = 16;
  localparam int DB_W = 1 << ID_W;

  logic clk = 0, rst_n = 0, start = 0;
  logic [ID_W-1:0] own_id = 0, tgt_id = 0;
  logic bsy_out_n, sel_out_n, dbp_out_n, busy, arb_lost, sel_ok, sel_fail;
  logic [DB_W-1:0] db_out_n;
  logic oth_bsy_n = 1, tgt_bsy_n = 1;
  logic [DB_W-1:0] oth_db_n = '1;
  logic bsy_in_n, sel_in_n;
  logic [DB_W-1:0] db_in_n;
  int total = 0, bad = 0, resp_delay = 3;
  bit resp_en = 1;
  int expq[$];

  assign bsy_in_n = bsy_out_n & oth_bsy_n & tgt_bsy_n;
  assign sel_in_n = sel_out_n;
  assign db_in_n  = db_out_n & oth_db_n;

  always #4 clk = ~clk;

  idbus_selector #(.ID_W(ID_W), .FREE_CLKS(FREE), .ARB_CLKS(ARB), .SEL_TMO(TMO)) dut (
    .clk, .rst_n, .start, .own_id, .tgt_id, .bsy_in_n, .sel_in_n, .db_in_n,
    .bsy_out_n, .sel_out_n, .db_out_n, .dbp_out_n, .busy, .arb_lost, .sel_ok, .sel_fail);

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input int o, input int t);
    @(negedge clk);
    own_id = ID_W'(o); tgt_id = ID_W'(t); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic push(input int code);
    expq.push_back(code);
  endtask

  // scoreboard monitor: 1 = lost, 2 = ok, 3 = fail
  always @(negedge clk) begin
    if (rst_n && (arb_lost | sel_ok | sel_fail)) begin
      int code, e;
      code = arb_lost ? 1 : (sel_ok ? 2 : 3);
      e = (expq.size() > 0) ? expq.pop_front() : 0;
      chk(code == e, code == 1 ? "R5" : (code == 2 ? "R8" : "R9"), "result", code, e);
    end
  end

  // target responder
  initial forever begin
    @(negedge clk);
    if (resp_en && !sel_in_n && bsy_out_n && tgt_bsy_n) begin
      repeat (resp_delay) @(negedge clk);
      tgt_bsy_n = 0;
      while (!sel_in_n) @(negedge clk);
      tgt_bsy_n = 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1
    chk(bsy_out_n && sel_out_n && dbp_out_n && db_out_n == '1, "R1", "lines released", db_out_n, 8'hff);
    chk(!busy && !arb_lost && !sel_ok && !sel_fail, "R1", "flags", busy, 0);
    rst_n = 1;

    // R2: self-addressed request ignored
    do_start(3, 3);
    repeat (10) @(negedge clk);
    chk(!busy && bsy_out_n && db_out_n == '1, "R2", "self select ignored", busy, 0);

    // R3 / R4 / R6 / R7 / R8: clean bus, target answers
    oth_bsy_n = 0; resp_delay = 3; resp_en = 1;
    push(2);
    do_start(2, 0);
    repeat (12) @(negedge clk);
    chk(bsy_out_n == 1, "R3", "no arbitration while busy", bsy_out_n, 1);
    oth_bsy_n = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (bsy_out_n && n < 50);
    chk(n == FREE, "R3", "bus free delay", n, FREE);
    chk(db_out_n == ~8'h04, "R4", "own line only", db_out_n, ~8'h04);
    chk(sel_out_n == 1, "R4", "select released", sel_out_n, 1);
    chk(dbp_out_n == 1, "R7", "parity with one line", dbp_out_n, 1);
    while (sel_out_n) @(negedge clk);
    chk(bsy_out_n == 0, "R6", "busy held with select", bsy_out_n, 0);
    chk(db_out_n == ~8'h05, "R6", "own and target lines", db_out_n, ~8'h05);
    chk(dbp_out_n == 0, "R7", "parity with two lines", dbp_out_n, 0);
    @(negedge clk);
    chk(bsy_out_n == 1 && sel_out_n == 0, "R6", "busy released, select kept", {bsy_out_n, sel_out_n}, 2'b10);
    while (!sel_ok) @(negedge clk);
    chk(sel_out_n && db_out_n == '1 && !busy, "R8", "release on answer", db_out_n, 8'hff);
    repeat (3) @(negedge clk);

    // R5: lose to ID 6, then retry and win
    push(1); push(2);
    do_start(5, 1);
    while (bsy_out_n) @(negedge clk);
    oth_db_n = ~8'h44; oth_bsy_n = 0;
    while (!arb_lost) @(negedge clk);
    chk(bsy_out_n && db_out_n == '1 && busy, "R5", "withdraw after loss", db_out_n, 8'hff);
    repeat (6) @(negedge clk);
    chk(bsy_out_n == 1, "R3", "wait after loss", bsy_out_n, 1);
    oth_db_n = '1; oth_bsy_n = 1;
    while (!sel_ok) @(negedge clk);
    repeat (3) @(negedge clk);

    // R10: lower contenders 5 and 2, own ID 6 wins
    push(2);
    do_start(6, 4);
    while (bsy_out_n) @(negedge clk);
    oth_db_n = ~8'h24; oth_bsy_n = 0;
    while (sel_out_n) @(negedge clk);
    chk(db_out_n == ~8'h50, "R10", "highest ID selects", db_out_n, ~8'h50);
    oth_db_n = '1; oth_bsy_n = 1;
    while (!sel_ok) @(negedge clk);
    repeat (3) @(negedge clk);

    // R9: no answer, plus R2 start while busy
    resp_en = 0;
    push(3);
    do_start(1, 7);
    while (!(sel_out_n == 0 && bsy_out_n == 1)) @(negedge clk);
    chk(db_out_n == ~8'h82 && dbp_out_n == 0, "R7", "selection lines and parity", db_out_n, ~8'h82);
    n = 0;
    @(negedge clk); own_id = 1; tgt_id = 3; start = 1; n++;
    @(negedge clk); start = 0; n++;
    chk(db_out_n == ~8'h82, "R2", "start while busy ignored", db_out_n, ~8'h82);
    while (!sel_fail && n < 100) begin @(negedge clk); n++; end
    chk(n == TMO, "R9", "timeout length", n, TMO);
    chk(sel_out_n && db_out_n == '1 && !busy, "R9", "release on timeout", db_out_n, 8'hff);

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R8", "all results seen", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule